// File: doc/BRIEF.md
# Shared-Multiplier FIR Filter

This block is a finite impulse response filter built around a single multiply-accumulate unit. Each accepted input sample is stored into a circular sample memory. The block then spends one clock cycle per tap. In each of those cycles it multiplies one stored sample by one coefficient from a constant table and adds the product into a wide accumulator. When every tap has been summed, a capture register presents the full-precision result together with a one-cycle valid flag.

The block trades rate for area. It takes at most one sample per computation of roughly TAPS cycles, and it needs only one multiplier whatever the filter length. The input uses a valid/ready handshake and is refused while a computation is running. The tap count and the sample and coefficient widths are parameters. The coefficients are computed from a fixed formula at elaboration.

Top module: `mac_fir`

## Requirements
- R1: While `rst` is high and after it falls, `inReady` is 1, `outValid` is 0 and `outData` is 0. Reset also empties every sample slot to zero, so the first result after reset involves only the first accepted sample.
- R2: `inReady` is 1 only when no computation is running. It is 0 from the clock edge that accepts a sample until the cycle in which that sample's result is flagged valid.
- R3: A sample is accepted only on a rising edge where both `inValid` and `inReady` are 1. Data offered while `inReady` is 0 is not stored and does not change any later result.
- R4: Coefficient i, for i from 0 to TAPS-1, is ((5*i) mod 17) - 8 as a signed value. Let slot p be the slot that receives the newest sample. The result is the sum over i of coefficient i times the content of slot (p+i) mod TAPS. So coefficient 0 weighs the newest sample, and coefficient i (i>0) weighs the sample accepted TAPS-i acceptances earlier.
- R5: `outValid` rises exactly TAPS+1 rising edges after the accepting edge and stays high for exactly one cycle.
- R6: `outData` is signed and SAMPLE_W+COEF_W+ceil(log2(TAPS)) bits wide. It carries the exact sum without wrap, even when every sample is at its most positive or most negative value.
- R7: `outData` holds its value in every cycle in which `outValid` is 0.
- R8: The write slot advances by one per accepted sample and wraps from TAPS-1 back to 0, so results stay correct over runs longer than TAPS samples.
- R9: In the cycle in which `outValid` is 1, `inReady` is already 1. A sample offered in that cycle is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input sample offered |
| inData | input | SAMPLE_W | Signed input sample |
| inReady | output | 1 | Engine idle, sample can be taken |
| outValid | output | 1 | One-cycle flag for a new result |
| outData | output | SAMPLE_W+COEF_W+ceil(log2(TAPS)) | Signed full-precision filter result |

## Verification
Two functions can meet in one cycle: presenting a finished result and accepting the next sample. The bench provokes this by driving a new sample in the very cycle in which it sees `outValid` high. That collision makes the write slot move on while the just-captured result must stay intact. The outcome is judged by checking that the new sample's result appears exactly TAPS+1 edges later with the value the bench's own circular-buffer model predicts. The bench also offers junk data during busy periods. That data must leave every later result unchanged.

// File: rtl/mac_fir_pkg.sv
package mac_fir_pkg;

  // Strobes sent from the sequencer to the datapath
  typedef struct packed {
    logic loadSample;   // write inData into the current slot
    logic clearAcc;     // start a fresh sum
    logic macStep;      // add one product
    logic capture;      // copy the sum to the output register
    logic advancePtr;   // move the write slot on
  } firStrobe_t;

  // Coefficient formula, evaluated at elaboration
  function automatic int coefValue(input int idx);
    return ((idx * 5) % 17) - 8;
  endfunction

endpackage

// File: rtl/mac_fir_ctrl.sv
module mac_fir_ctrl
  import mac_fir_pkg::*;
#(
  parameter int TAPS  = 31,
  parameter int IDX_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  output firStrobe_t       strobe,
  output logic [IDX_W-1:0] tapIdx
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} seqState_t;

  seqState_t state;
  logic      accept;
  logic      lastTap;

  assign inReady = (state == ST_IDLE);
  assign accept  = inReady && inValid;
  assign lastTap = (tapIdx == IDX_W'(TAPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      tapIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          tapIdx <= '0;
          if (accept) state <= ST_RUN;
        end
        ST_RUN: begin
          if (lastTap) begin
            state  <= ST_DONE;
            tapIdx <= '0;
          end else begin
            tapIdx <= tapIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.loadSample = accept;
    strobe.clearAcc   = accept;
    strobe.macStep    = (state == ST_RUN);
    strobe.capture    = (state == ST_DONE);
    strobe.advancePtr = (state == ST_DONE);
  end

endmodule

// File: rtl/mac_fir_dp.sv
module mac_fir_dp
  import mac_fir_pkg::*;
#(
  parameter int TAPS     = 31,
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 16,
  parameter int IDX_W    = $clog2(TAPS),
  parameter int ACC_W    = SAMPLE_W + COEF_W + $clog2(TAPS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  firStrobe_t                 strobe,
  input  logic [IDX_W-1:0]           tapIdx,
  input  logic signed [SAMPLE_W-1:0] inData,
  output logic                       outValid,
  output logic signed [ACC_W-1:0]    outData
);

  localparam int PROD_W = SAMPLE_W + COEF_W;

  logic signed [SAMPLE_W-1:0] sampleMem [TAPS];
  logic signed [COEF_W-1:0]   coefRom   [TAPS];
  logic [IDX_W-1:0]           wrPtr;
  logic [IDX_W:0]             rawIdx;
  logic [IDX_W:0]             readIdx;
  logic signed [SAMPLE_W-1:0] sampleRd;
  logic signed [COEF_W-1:0]   coefRd;
  logic signed [PROD_W-1:0]   product;
  logic signed [ACC_W-1:0]    acc;

  for (genvar g = 0; g < TAPS; g++) begin : g_coef
    assign coefRom[g] = COEF_W'(coefValue(g));
  end

  // Read slot (wrPtr + tapIdx) mod TAPS
  assign rawIdx   = {1'b0, wrPtr} + {1'b0, tapIdx};
  assign readIdx  = (rawIdx >= (IDX_W+1)'(TAPS)) ? rawIdx - (IDX_W+1)'(TAPS) : rawIdx;
  assign sampleRd = sampleMem[readIdx[IDX_W-1:0]];
  assign coefRd   = coefRom[tapIdx];
  assign product  = sampleRd * coefRd;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) sampleMem[i] <= '0;
      wrPtr <= '0;
    end else begin
      if (strobe.loadSample) sampleMem[wrPtr] <= inData;
      if (strobe.advancePtr)
        wrPtr <= (wrPtr == IDX_W'(TAPS - 1)) ? '0 : wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      if (strobe.clearAcc)     acc <= '0;
      else if (strobe.macStep) acc <= acc + ACC_W'(product);
      if (strobe.capture) outData <= acc;
      outValid <= strobe.capture;
    end
  end

endmodule

// File: rtl/mac_fir.sv
module mac_fir
  import mac_fir_pkg::*;
#(
  parameter int TAPS     = 31,
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 16,
  localparam int IDX_W   = $clog2(TAPS),
  localparam int ACC_W   = SAMPLE_W + COEF_W + $clog2(TAPS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] inData,
  output logic                       inReady,
  output logic                       outValid,
  output logic signed [ACC_W-1:0]    outData
);

  firStrobe_t       strobe;
  logic [IDX_W-1:0] tapIdx;

  mac_fir_ctrl #(.TAPS(TAPS), .IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inReady (inReady),
    .strobe  (strobe),
    .tapIdx  (tapIdx)
  );

  mac_fir_dp #(
    .TAPS(TAPS), .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W),
    .IDX_W(IDX_W), .ACC_W(ACC_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .tapIdx   (tapIdx),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData)
  );

endmodule

// File: rtl/mac_fir_chk.sv
module mac_fir_chk #(
  parameter int TAPS  = 31,
  parameter int ACC_W = 37
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic [ACC_W-1:0] outData
);

  localparam int CNT_W = $clog2(TAPS + 3) + 1;

  logic [CNT_W-1:0] sinceAccept;

  always_ff @(posedge clk) begin
    if (rst)                      sinceAccept <= '0;
    else if (inValid && inReady)  sinceAccept <= CNT_W'(1);
    else if (outValid)            sinceAccept <= '0;
    else if (sinceAccept != '0)   sinceAccept <= sinceAccept + 1'b1;
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> (!inReady && !outValid)); // R2

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid); // R5

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (sinceAccept == CNT_W'(TAPS + 2))); // R5

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outData)); // R7

  AST_READY_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
    outValid |-> inReady); // R9

endmodule

bind mac_fir mac_fir_chk #(.TAPS(TAPS), .ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outData  (outData)
);

// File: tb/mac_fir_bench.sv
`timescale 1ns/1ps
module mac_fir_bench;

  localparam int TAPS     = 31;
  localparam int SAMPLE_W = 16;
  localparam int COEF_W   = 16;
  localparam int ACC_W    = SAMPLE_W + COEF_W + $clog2(TAPS);

  logic                       clk = 1'b0;
  logic                       rst = 1'b1;
  logic                       inValid = 1'b0;
  logic signed [SAMPLE_W-1:0] inData = '0;
  logic                       inReady;
  logic                       outValid;
  logic signed [ACC_W-1:0]    outData;

  int     nChecks = 0;
  int     nFails  = 0;
  longint mBuf [TAPS];
  int     mPtr = 0;
  longint lastY = 0;
  int     lcg = 12345;

  always #2.5 clk = ~clk;

  mac_fir #(.TAPS(TAPS), .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)) u_mac_fir (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outData(outData)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint benchCoef(input int i);
    return longint'(((5 * i) % 17) - 8);
  endfunction

  // Model: store, then sum coef[i] * slot[(p+i) mod TAPS], then advance
  function automatic longint modelAccept(input longint x);
    longint y = 0;
    mBuf[mPtr] = x;
    for (int i = 0; i < TAPS; i++) y += benchCoef(i) * mBuf[(mPtr + i) % TAPS];
    mPtr = (mPtr + 1) % TAPS;
    return y;
  endfunction

  // Called at a negedge; returns at the negedge where the result is flagged
  task automatic pushSample(input longint x, input bit noise, input string req);
    longint expY;
    bit     timingOk = 1'b1;
    while (!inReady) @(negedge clk);
    inValid = 1'b1;
    inData  = SAMPLE_W'(x);
    expY    = modelAccept(x);
    for (int k = 1; k <= TAPS + 2; k++) begin
      @(negedge clk);
      if (k == 1) begin
        inValid = noise;
        inData  = SAMPLE_W'(x) ^ 16'h5A5A;
      end
      if (k < TAPS + 2 && (outValid || inReady)) timingOk = 1'b0;
    end
    check(timingOk, "R2/R5 busy window", longint'(timingOk), 1);
    check(outValid === 1'b1, "R5 valid at TAPS+1", longint'(outValid), 1);
    check(inReady === 1'b1, "R9 ready with result", longint'(inReady), 1);
    check(longint'(outData) == expY, req, longint'(outData), expY);
    lastY   = expY;
    inValid = 1'b0;
  endtask

  task automatic idleGap(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(outValid === 1'b0, "R5 single pulse", longint'(outValid), 0);
      check(longint'(outData) == lastY, "R7 hold", longint'(outData), lastY);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < TAPS; i++) mBuf[i] = 0;
    repeat (3) @(negedge clk);
    check(inReady === 1'b1, "R1 ready in reset", longint'(inReady), 1);
    check(outValid === 1'b0, "R1 valid in reset", longint'(outValid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(inReady === 1'b1, "R1 ready after reset", longint'(inReady), 1);
    check(outValid === 1'b0, "R1 valid after reset", longint'(outValid), 0);
    check(longint'(outData) == 0, "R1 data after reset", longint'(outData), 0);

    // Impulse: first result sees only coefficient 0 (R1, R4)
    pushSample(1000, 1'b0, "R1 empty buffer impulse");
    // Zeros walk the impulse through every tap, junk offered while busy (R3, R4)
    for (int j = 0; j < TAPS + 4; j++) pushSample(0, 1'b1, "R3/R4 impulse sweep");
    idleGap(3);

    // Pseudo-random run longer than TAPS, wrapping the slot (R8), mixed gaps
    for (int j = 0; j < 70; j++) begin
      lcg = lcg * 1103515245 + 12345;
      pushSample(longint'($signed(lcg[23:8])), j[0], "R8 wrap random");
      if (j % 5 == 0) idleGap(2);
    end

    // Extremes for full precision (R6)
    for (int j = 0; j < TAPS; j++) pushSample(32767, 1'b0, "R6 max positive");
    for (int j = 0; j < TAPS; j++) pushSample(-32768, 1'b1, "R6 max negative");
    idleGap(4);

    // Back-to-back: one more sample right at a valid cycle (R9)
    pushSample(-5, 1'b0, "R9 back-to-back first");
    pushSample(7, 1'b0, "R9 back-to-back second");
    idleGap(2);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule